// File: doc/BRIEF.md
# Potentiometer Data Register Bank

This block holds the saved settings of a four-channel digital potentiometer: four 6-bit data registers for each of four pots, sixteen entries in all. The command decoder hands it store requests of three kinds: a host write of a byte, a copy of one pot's wiper position into one of that pot's registers, and a global copy that writes every pot's wiper position into the same register index of each pot. Flip-flops stand in for nonvolatile cells, but the bank keeps the timing a nonvolatile store would have.

A request is only staged while a frame is open. The bank commits it when the chip-select rising edge arrives, reported by the decoder as `cs_rise_i`, and only if the write-protect input is high. A commit starts a busy window of `BUSY_CYCLES` clocks. During that window `wip_o` is high, reads still return the old contents, and further requests are dropped. The new contents appear in the cycle the window closes. Register 0 of every pot is always presented on `boot_o`, which is the value the wiper logic loads at start-up.

Top module: `dreg_bank`

## Requirements
- R1: After reset all sixteen entries read 0 and `wip_o` is 0.
- R2: A host write (`req_kind_i` = 2'b01) to pot `req_pot_i`, register `req_reg_i` with `req_data_i` changes no entry before `cs_rise_i`. After the commit it becomes visible at the read port, which addresses entry {`rd_pot_i`, `rd_reg_i`}.
- R3: A commit on the clock edge that samples `cs_rise_i` high raises `wip_o` at that edge. `wip_o` then stays high for exactly `BUSY_CYCLES` cycles.
- R4: While `wip_o` is high, reads return the previous contents. The committed value appears in the same cycle that `wip_o` falls.
- R5: If `wp_n_i` is low when `cs_rise_i` arrives, nothing is stored, `wip_o` stays 0 and the staged request is discarded.
- R6: A request that arrives while `wip_o` is high, including in the last busy cycle, is ignored. A later `cs_rise_i` then stores nothing.
- R7: A single transfer (`req_kind_i` = 2'b10) stores the wiper slice of pot `req_pot_i`, which is `wiper_i[p*6 +: 6]` for pot p, into that pot's register `req_reg_i`.
- R8: A global transfer (`req_kind_i` = 2'b11) stores each pot's wiper slice into register `req_reg_i` of all four pots in one commit. It ignores `req_pot_i` and leaves the other registers unchanged.
- R9: When a frame stages several requests, only the last one is committed, in a single busy window.
- R10: A request presented in the same cycle as `cs_rise_i` belongs to the closing frame and is committed.
- R11: `boot_o[p*6 +: 6]` always shows register 0 of pot p.
- R12: A `cs_rise_i` with no staged request starts no busy window.
- R13: A transfer captures the wiper value in the cycle of the request, not at `cs_rise_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_kind_i | input | 2 | Store request: 00 none, 01 host write, 10 single transfer, 11 global transfer |
| req_pot_i | input | 2 | Target pot of a host write or single transfer |
| req_reg_i | input | 2 | Target register index |
| req_data_i | input | 6 | Data for a host write |
| wiper_i | input | 24 | Current wiper positions, pot p in bits [p*6 +: 6] |
| cs_rise_i | input | 1 | Frame end: one-cycle pulse at the chip-select rising edge |
| wp_n_i | input | 1 | Store enable; low blocks every commit |
| rd_pot_i | input | 2 | Read port pot select |
| rd_reg_i | input | 2 | Read port register select |
| rd_data_o | output | 6 | Combinational read data |
| boot_o | output | 24 | Register 0 of each pot, pot p in bits [p*6 +: 6] |
| wip_o | output | 1 | Store in progress |

## Verification
Two events can fall in the same cycle. The first is the end of the busy window together with a new store request. The bench puts a host write on the last cycle in which `wip_o` is high and follows it with a frame end. It then checks that `wip_o` stays low and that the target entry keeps its old value. The second is a frame end together with a request: the bench raises `cs_rise_i` in the same cycle as a host write or global transfer and checks that exactly that request is committed and that an earlier request in the same frame is lost.

// File: rtl/dreg_pkg.sv
package dreg_pkg;

    typedef enum logic [1:0] {
        REQ_NONE   = 2'b00,
        REQ_HOST   = 2'b01,
        REQ_XFER   = 2'b10,
        REQ_GLOBAL = 2'b11
    } req_kind_e;

endpackage

// File: rtl/dreg_stage.sv
module dreg_stage
    import dreg_pkg::*;
#(
    parameter int POTS = 4,
    parameter int REGS = 4,
    parameter int DW   = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           req_kind_i,
    input  logic [$clog2(POTS)-1:0] req_pot_i,
    input  logic [$clog2(REGS)-1:0] req_reg_i,
    input  logic [DW-1:0]        req_data_i,
    input  logic [POTS*DW-1:0]   wiper_i,
    input  logic                 cs_rise_i,
    input  logic                 wp_n_i,
    input  logic                 busy_i,
    output logic                 commit_o,
    output logic [POTS-1:0]      commit_mask_o,
    output logic [$clog2(REGS)-1:0] commit_reg_o,
    output logic [POTS*DW-1:0]   commit_data_o
);
    localparam int PW = $clog2(POTS);
    localparam int RW = $clog2(REGS);

    typedef struct packed {
        logic                    valid;
        logic [POTS-1:0]         mask;
        logic [RW-1:0]           rsel;
        logic [POTS-1:0][DW-1:0] data;
    } pend_t;

    pend_t     pend_q, pend_d;
    pend_t     incoming;
    pend_t     merged;
    logic      accept;
    req_kind_e kind;

    always_comb begin
        kind          = req_kind_e'(req_kind_i);
        incoming      = '0;
        incoming.rsel = req_reg_i;
        accept        = (kind != REQ_NONE) && !busy_i;

        case (kind)
            REQ_HOST: begin
                incoming.valid           = 1'b1;
                incoming.mask[req_pot_i] = 1'b1;
                incoming.data[req_pot_i] = req_data_i;
            end
            REQ_XFER: begin
                incoming.valid           = 1'b1;
                incoming.mask[req_pot_i] = 1'b1;
                incoming.data            = wiper_i;
            end
            REQ_GLOBAL: begin
                incoming.valid = 1'b1;
                incoming.mask  = '1;
                incoming.data  = wiper_i;
            end
            default: begin
                incoming.valid = 1'b0;
            end
        endcase

        merged = accept ? incoming : pend_q;

        commit_o      = cs_rise_i && merged.valid && wp_n_i && !busy_i;
        commit_mask_o = merged.mask;
        commit_reg_o  = merged.rsel;
        commit_data_o = merged.data;

        pend_d = cs_rise_i ? '0 : merged;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    logic unused_pw;
    assign unused_pw = ^PW;

endmodule

// File: rtl/dreg_timer.sv
module dreg_timer #(
    parameter int BUSY_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic wip_o,
    output logic done_o
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_q, tmr_d;

    always_comb begin
        tmr_d = tmr_q;
        if (start_i) begin
            tmr_d.cnt = CW'(BUSY_CYCLES);
        end else if (tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - CW'(1);
        end
        wip_o  = (tmr_q.cnt != '0);
        done_o = (tmr_q.cnt == CW'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

endmodule

// File: rtl/dreg_array.sv
module dreg_array #(
    parameter int POTS = 4,
    parameter int REGS = 4,
    parameter int DW   = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    commit_i,
    input  logic [POTS-1:0]         commit_mask_i,
    input  logic [$clog2(REGS)-1:0] commit_reg_i,
    input  logic [POTS*DW-1:0]      commit_data_i,
    input  logic                    done_i,
    input  logic [$clog2(POTS)-1:0] rd_pot_i,
    input  logic [$clog2(REGS)-1:0] rd_reg_i,
    output logic [DW-1:0]           rd_data_o,
    output logic [POTS*DW-1:0]      boot_o
);
    localparam int PW      = $clog2(POTS);
    localparam int RW      = $clog2(REGS);
    localparam int ENTRIES = POTS * REGS;

    typedef struct packed {
        logic [POTS-1:0]         mask;
        logic [RW-1:0]           rsel;
        logic [POTS-1:0][DW-1:0] data;
    } wbuf_t;

    typedef struct packed {
        logic [ENTRIES-1:0][DW-1:0] mem;
        wbuf_t                      wbuf;
    } arr_t;

    arr_t arr_q, arr_d;

    always_comb begin
        arr_d = arr_q;
        if (commit_i) begin
            arr_d.wbuf.mask = commit_mask_i;
            arr_d.wbuf.rsel = commit_reg_i;
            arr_d.wbuf.data = commit_data_i;
        end
        if (done_i) begin
            for (int p = 0; p < POTS; p++) begin
                if (arr_q.wbuf.mask[p]) begin
                    arr_d.mem[{PW'(p), arr_q.wbuf.rsel}] = arr_q.wbuf.data[p];
                end
            end
        end
        rd_data_o = arr_q.mem[{rd_pot_i, rd_reg_i}];
    end

    for (genvar p = 0; p < POTS; p++) begin : g_boot
        assign boot_o[p*DW +: DW] = arr_q.mem[p*REGS];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arr_q <= '0;
        end else begin
            arr_q <= arr_d;
        end
    end

endmodule

// File: rtl/dreg_bank.sv
module dreg_bank #(
    parameter int POTS        = 4,
    parameter int REGS        = 4,
    parameter int DW          = 6,
    parameter int BUSY_CYCLES = 500000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              req_kind_i,
    input  logic [$clog2(POTS)-1:0] req_pot_i,
    input  logic [$clog2(REGS)-1:0] req_reg_i,
    input  logic [DW-1:0]           req_data_i,
    input  logic [POTS*DW-1:0]      wiper_i,
    input  logic                    cs_rise_i,
    input  logic                    wp_n_i,
    input  logic [$clog2(POTS)-1:0] rd_pot_i,
    input  logic [$clog2(REGS)-1:0] rd_reg_i,
    output logic [DW-1:0]           rd_data_o,
    output logic [POTS*DW-1:0]      boot_o,
    output logic                    wip_o
);
    localparam int RW = $clog2(REGS);

    logic               commit;
    logic [POTS-1:0]    commit_mask;
    logic [RW-1:0]      commit_reg;
    logic [POTS*DW-1:0] commit_data;
    logic               busy;
    logic               done;

    dreg_stage #(.POTS(POTS), .REGS(REGS), .DW(DW)) u_stage (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_kind_i    (req_kind_i),
        .req_pot_i     (req_pot_i),
        .req_reg_i     (req_reg_i),
        .req_data_i    (req_data_i),
        .wiper_i       (wiper_i),
        .cs_rise_i     (cs_rise_i),
        .wp_n_i        (wp_n_i),
        .busy_i        (busy),
        .commit_o      (commit),
        .commit_mask_o (commit_mask),
        .commit_reg_o  (commit_reg),
        .commit_data_o (commit_data)
    );

    dreg_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (commit),
        .wip_o   (busy),
        .done_o  (done)
    );

    dreg_array #(.POTS(POTS), .REGS(REGS), .DW(DW)) u_array (
        .clk           (clk),
        .rst_n         (rst_n),
        .commit_i      (commit),
        .commit_mask_i (commit_mask),
        .commit_reg_i  (commit_reg),
        .commit_data_i (commit_data),
        .done_i        (done),
        .rd_pot_i      (rd_pot_i),
        .rd_reg_i      (rd_reg_i),
        .rd_data_o     (rd_data_o),
        .boot_o        (boot_o)
    );

    assign wip_o = busy;

endmodule

// File: rtl/dreg_bank_chk.sv
module dreg_bank_chk #(
    parameter int BUSY_CYCLES = 500000,
    parameter int BOOT_W      = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_rise_i,
    input logic              wp_n_i,
    input logic              wip_o,
    input logic [BOOT_W-1:0] boot_o
);
    int run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 0;
        end else if (!wip_o) begin
            run_q <= 0;
        end else begin
            run_q <= run_q + 1;
        end
    end

    AST_WIP_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip_o) |-> $past(cs_rise_i && wp_n_i)); // R3

    AST_WP_BLOCKS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise_i && !wp_n_i && !wip_o) |=> !wip_o); // R5

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip_o) |-> (run_q == BUSY_CYCLES)); // R3

    AST_OLD_DATA_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (wip_o && $past(wip_o)) |-> $stable(boot_o)); // R4

    AST_NO_EARLY_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wip_o) |-> $stable(boot_o)); // R2

endmodule

bind dreg_bank dreg_bank_chk #(
    .BUSY_CYCLES (BUSY_CYCLES),
    .BOOT_W      (POTS*DW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_rise_i (cs_rise_i),
    .wp_n_i    (wp_n_i),
    .wip_o     (wip_o),
    .boot_o    (boot_o)
);

// File: tb/sim_dreg_bank.sv
`timescale 1ns/1ps
module sim_dreg_bank;
    localparam int POTS = 4;
    localparam int REGS = 4;
    localparam int DW   = 6;
    localparam int BUSY = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        req_kind = '0;
    logic [1:0]        req_pot = '0;
    logic [1:0]        req_reg = '0;
    logic [DW-1:0]     req_data = '0;
    logic [POTS*DW-1:0] wiper = '0;
    logic              cs_rise = 1'b0;
    logic              wp_n = 1'b1;
    logic [1:0]        rd_pot = '0;
    logic [1:0]        rd_reg = '0;
    logic [DW-1:0]     rd_data;
    logic [POTS*DW-1:0] boot;
    logic              wip;

    always #2 clk = ~clk;

    dreg_bank #(.POTS(POTS), .REGS(REGS), .DW(DW), .BUSY_CYCLES(BUSY)) u0 (
        .clk (clk), .rst_n (rst_n), .req_kind_i (req_kind), .req_pot_i (req_pot),
        .req_reg_i (req_reg), .req_data_i (req_data), .wiper_i (wiper),
        .cs_rise_i (cs_rise), .wp_n_i (wp_n), .rd_pot_i (rd_pot), .rd_reg_i (rd_reg),
        .rd_data_o (rd_data), .boot_o (boot), .wip_o (wip)
    );

    typedef struct {
        int    sel;
        int    pot;
        int    exp;
        string tag;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    failures = 0;
    bit    finished = 1'b0;

    // scoreboard monitor: compares queued expectations after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                int    act;
                it = q.pop_front();
                case (it.sel)
                    0:       act = int'(wip);
                    1:       act = int'(rd_data);
                    default: act = int'(boot[it.pot*DW +: DW]);
                endcase
                checks++;
                if (act != it.exp) begin
                    failures++;
                    $display("FAIL %s actual=%0d expected=%0d", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic step();
        @(negedge clk);
        req_kind = 2'b00;
        cs_rise  = 1'b0;
    endtask

    task automatic exp_wip(int v, string tag);
        q.push_back('{0, 0, v, tag});
    endtask

    task automatic exp_rd(int p, int r, int v, string tag);
        rd_pot = p[1:0];
        rd_reg = r[1:0];
        q.push_back('{1, p, v, tag});
    endtask

    task automatic exp_boot(int p, int v, string tag);
        q.push_back('{2, p, v, tag});
    endtask

    task automatic req(int kind, int p, int r, int d);
        req_kind = kind[1:0];
        req_pot  = p[1:0];
        req_reg  = r[1:0];
        req_data = d[DW-1:0];
    endtask

    task automatic set_wiper(int p, int v);
        wiper[p*DW +: DW] = v[DW-1:0];
    endtask

    // caller has just driven the committing cs_rise
    task automatic wait_busy(string tag, int p, int r, int oldv, int newv);
        for (int k = 1; k <= BUSY; k++) begin
            step();
            exp_wip(1, {tag, " R3 wip high in window"});
            if (k == 1 || k == BUSY) exp_rd(p, r, oldv, {tag, " R4 old data while busy"});
        end
        step();
        exp_wip(0, {tag, " R3 wip falls after window"});
        exp_rd(p, r, newv, {tag, " R4 new data at window end"});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        step(); exp_wip(0, "R1 wip after reset");
        for (int i = 0; i < POTS*REGS; i++) begin
            step(); exp_rd(i / REGS, i % REGS, 0, "R1 entry zero after reset");
        end
        step(); for (int p = 0; p < POTS; p++) exp_boot(p, 0, "R11 boot zero after reset");

        // R2: host write deferred to frame end
        step(); req(1, 1, 2, 6'h2A);
        step(); exp_rd(1, 2, 0, "R2 no store before frame end"); exp_wip(0, "R2 no busy before frame end");
        step(); exp_rd(1, 2, 0, "R2 still deferred");
        step(); cs_rise = 1'b1;
        wait_busy("R2 host write", 1, 2, 0, 6'h2A);

        // R5: write protect blocks commit and discards staged request
        step(); wp_n = 1'b0; req(1, 2, 3, 6'h15);
        step(); cs_rise = 1'b1;
        step(); exp_wip(0, "R5 no busy under protect");
        step(); exp_rd(2, 3, 0, "R5 entry unchanged"); wp_n = 1'b1; cs_rise = 1'b1;
        step(); exp_wip(0, "R12 empty frame end starts no busy");
        step(); exp_wip(0, "R12 still idle"); exp_rd(2, 3, 0, "R5 staged request discarded");

        // R7 and R13: single transfer captures wiper at request time
        step(); set_wiper(0, 5); set_wiper(1, 10); set_wiper(2, 20); set_wiper(3, 40);
        req(2, 3, 1, 0);
        step(); set_wiper(3, 63); cs_rise = 1'b1;
        wait_busy("R7 R13 single transfer", 3, 1, 0, 40);

        // R8 R10 R11: global transfer in same cycle as frame end
        step(); set_wiper(0, 11); set_wiper(1, 22); set_wiper(2, 33); set_wiper(3, 44);
        req(3, 2, 0, 0); cs_rise = 1'b1;
        wait_busy("R8 R10 global transfer", 0, 0, 0, 11);
        step(); exp_rd(1, 0, 22, "R8 pot1 reg0");
        step(); exp_rd(2, 0, 33, "R8 pot2 reg0");
        step(); exp_rd(3, 0, 44, "R8 pot3 reg0");
        step(); exp_rd(3, 1, 40, "R8 other register untouched");
        step(); exp_boot(0, 11, "R11 boot pot0"); exp_boot(1, 22, "R11 boot pot1");
        exp_boot(2, 33, "R11 boot pot2"); exp_boot(3, 44, "R11 boot pot3");

        // R9 R10: last request of frame wins, presented with frame end
        step(); req(1, 2, 0, 1);
        step(); req(1, 2, 1, 6'h3F); cs_rise = 1'b1;
        wait_busy("R9 R10 last wins", 2, 1, 0, 6'h3F);
        step(); exp_rd(2, 0, 33, "R9 earlier request dropped");

        // R6: requests during busy ignored, incl. last busy cycle
        step(); req(1, 0, 3, 6'h11); cs_rise = 1'b1;
        for (int k = 1; k <= BUSY; k++) begin
            step();
            exp_wip(1, "R6 R3 wip high");
            if (k == 2) req(1, 1, 1, 6'h33);
            if (k == 3) cs_rise = 1'b1;
            if (k == BUSY) req(1, 1, 2, 6'h07);
        end
        step(); exp_wip(0, "R6 R3 window ends once"); cs_rise = 1'b1;
        step(); exp_wip(0, "R6 no commit of dropped request"); exp_rd(1, 1, 0, "R6 busy request ignored");
        step(); exp_wip(0, "R6 still idle"); exp_rd(1, 2, 6'h2A, "R6 last-cycle request ignored");
        step(); exp_rd(0, 3, 6'h11, "R6 first commit stored");

        step(); step();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule